// File: doc/BRIEF.md
# Slow Oscillator Activity Checker

This block decides whether a slow real-time-clock oscillator is alive. It watches a free-running counter that the oscillator advances. The counter arrives as a Gray-coded value from the slow clock domain. A start pulse makes the block raise a count-force output, so the counter is made to advance. The block then waits a short settle time so the synchronized value can be trusted, and takes a first snapshot. It waits a fixed window measured in system clock cycles and takes a second snapshot. After that it drops the force output. If the two snapshots match, nothing moved and the oscillator is judged dead.

The outcome is reported with a one-cycle done pulse and a fail flag that holds its value until the next accepted start. An attach-enable output allows downstream time-of-day access only after a passing check. The default window is 5000 cycles, which is 50 microseconds at 100 MHz. That is longer than one period of a 32.768 kHz clock. The slow counter cannot be stalled, so it is a plain sampled input and not a valid/ready stream. All other pins are plain control and status levels.

Top module: `osc_activity_check`

## Requirements
- R1: While reset is held and in the first cycle after it, count_force_o, done_o, fail_o and attach_en_o are all 0.
- R2: count_force_o rises in the cycle after a start is accepted. It stays 1 through the whole check and is 0 in the cycle where done_o is 1.
- R3: The first snapshot is taken SETTLE_CYC cycles after the accepted start edge and the second one WINDOW_CYC cycles after that. done_o is therefore 1 exactly SETTLE_CYC+WINDOW_CYC clock edges after the edge that accepted the start.
- R4: fail_o is 1 when the two snapshots are equal, for example when the oscillator is stopped. It is 0 when they differ.
- R5: done_o is a single-cycle pulse. fail_o keeps the result until the next accepted start, which clears it to 0 in the following cycle.
- R6: attach_en_o is 1 only after a check that passed, and it is the inverse of fail_o when done_o is 1. It is cleared in the cycle after an accepted start.
- R7: A start_i pulse that arrives while a check is running is ignored. The running check keeps its timing and produces exactly one done pulse.
- R8: slow_cnt_gray_i is a CNT_W-bit reflected Gray code (bit i of the binary count XOR bit i+1). It passes through two flip-flops before it is converted and compared, and a counter wrap from all-ones to zero during the window still counts as activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a check; accepted only when idle |
| slow_cnt_gray_i | input | CNT_W | Gray-coded slow counter value, asynchronous to clk |
| count_force_o | output | 1 | Forces the slow counter to count during a check |
| done_o | output | 1 | One-cycle pulse when a check completes |
| fail_o | output | 1 | 1 if the counter did not move; held until next start |
| attach_en_o | output | 1 | Enables downstream time-of-day access after a pass |

## Verification
The bench runs oscillators at random slow periods, a stopped oscillator, a counter preloaded just below its wrap point, and start pulses injected in the middle of a window. Each case checks the done timing and the result against values the bench computes itself.
- A design that took the second snapshot too early, or never forced the counter, would report a live oscillator as failed.
- A design that compared the unsynchronized value would see no difference, or a spurious one, across a wrap.
- A design that re-armed on a busy start would shift or double its done pulse.
- A design that lost the held result would show fail or attach-enable changing between checks.

// File: rtl/osc_chk_pkg.sv
package osc_chk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WINDOW = 2'd2
  } osc_chk_state_e;
endpackage

// File: rtl/osc_chk_sync.sv
module osc_chk_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_async_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_async_i;
      stab_q <= meta_q;
    end
  end

  // Gray to binary conversion: each binary bit is the XOR of all Gray bits at or above it
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_o[i] = ^(stab_q >> i);
    end
  end
endmodule

// File: rtl/osc_chk_timer.sv
module osc_chk_timer #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == limit_i - 1'b1);

  // R3: the counter never runs past the selected limit
  p_tmr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit_i);
endmodule

// File: rtl/osc_activity_check.sv
module osc_activity_check
  import osc_chk_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WINDOW_CYC = 5000,
  parameter int SETTLE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] slow_cnt_gray_i,
  output logic             count_force_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             attach_en_o
);
  localparam int MAXC = (WINDOW_CYC > SETTLE_CYC) ? WINDOW_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  osc_chk_state_e  state_q;
  logic [CNT_W-1:0] cnt_bin, snap_q;
  logic [TW-1:0]    tmr_lim;
  logic             tmr_clr, tmr_last;

  osc_chk_sync #(.W(CNT_W)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .gray_async_i (slow_cnt_gray_i),
    .bin_o        (cnt_bin)
  );

  assign tmr_lim = (state_q == ST_SETTLE) ? TW'(SETTLE_CYC) : TW'(WINDOW_CYC);
  assign tmr_clr = (state_q == ST_IDLE) || tmr_last;

  osc_chk_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .limit_i (tmr_lim),
    .last_o  (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      snap_q        <= '0;
      count_force_o <= 1'b0;
      done_o        <= 1'b0;
      fail_o        <= 1'b0;
      attach_en_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q       <= ST_SETTLE;
          count_force_o <= 1'b1;
          fail_o        <= 1'b0;
          attach_en_o   <= 1'b0;
        end
        ST_SETTLE: if (tmr_last) begin
          snap_q  <= cnt_bin;
          state_q <= ST_WINDOW;
        end
        ST_WINDOW: if (tmr_last) begin
          fail_o        <= (cnt_bin == snap_q);
          attach_en_o   <= (cnt_bin != snap_q);
          count_force_o <= 1'b0;
          done_o        <= 1'b1;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start raises the force in the next cycle
  p_force_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> count_force_o);
  // R2: force is released when the result is reported
  p_force_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !count_force_o);
  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: result held between checks
  p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !count_force_o) |-> $stable(fail_o));
  // R6: attach enable is the inverse of fail when reported
  p_attach_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (attach_en_o != fail_o));
  // R7: a start during a check does not disturb the force output
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WINDOW && !tmr_last && start_i) |=> count_force_o);
endmodule

// File: tb/tb_osc_activity_check.sv
module tb_osc_activity_check;
  localparam int CW = 8;
  localparam int WIN = 400;
  localparam int SET = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] gray;
  logic force_o, done, fail, attach;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // slow counter model
  logic [CW-1:0] mcnt = '0;
  int div = 0;
  bit run = 1'b0;
  int per = 10;
  bit load_req = 1'b0;
  logic [CW-1:0] load_val = '0;

  always #5 clk = ~clk;

  osc_activity_check #(.CNT_W(CW), .WINDOW_CYC(WIN), .SETTLE_CYC(SET)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .slow_cnt_gray_i(gray),
    .count_force_o(force_o), .done_o(done), .fail_o(fail), .attach_en_o(attach)
  );

  always @(negedge clk) begin
    if (load_req) begin
      mcnt <= load_val;
      div  <= 0;
    end else if (run && force_o) begin
      if (div >= per - 1) begin
        div  <= 0;
        mcnt <= mcnt + 1'b1;
      end else begin
        div <= div + 1;
      end
    end
  end
  assign gray = mcnt ^ (mcnt >> 1);

  function automatic bit exp_fail(bit running);
    return !running;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_check(bit running, int period, logic [CW-1:0] pre, bit busy_poke);
    int n;
    bit force_ok;
    bit ef;
    int extra;
    ef = exp_fail(running);
    @(negedge clk);
    load_val = pre; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    run = running; per = period;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(force_o == 1'b1, "R2 force after start", force_o, 1);
    chk(fail == 1'b0 && attach == 1'b0, "R5/R6 cleared on start", {fail, attach}, 0);
    n = 0;
    force_ok = 1'b1;
    do begin
      if (busy_poke && n == 20) start = 1'b1;
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (!done && !force_o) force_ok = 1'b0;
    end while (!done && n < SET + WIN + 50);
    chk(force_ok, "R2 force held during check", force_ok, 1);
    chk(n == SET + WIN, "R3 done timing", n, SET + WIN);
    chk(done == 1'b1 && force_o == 1'b0, "R2 force released at done", force_o, 0);
    chk(fail == ef, running ? "R4/R8 live oscillator passes" : "R4 stopped oscillator fails", fail, ef);
    chk(attach == !ef, "R6 attach enable", attach, !ef);
    extra = 0;
    for (int k = 0; k < (busy_poke ? SET + WIN + 5 : 6); k++) begin
      @(negedge clk);
      if (done) extra++;
      if (fail != ef || attach != !ef) extra += 100;
    end
    chk(extra == 0, busy_poke ? "R7 busy start ignored" : "R5 done pulse and hold", extra, 0);
    run = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    chk({force_o, done, fail, attach} == 4'b0, "R1 reset outputs", {force_o, done, fail, attach}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({force_o, done, fail, attach} == 4'b0, "R1 after reset", {force_o, done, fail, attach}, 0);
    // directed corners
    run_check(1'b1, 4, 8'd0, 1'b0);
    run_check(1'b0, 10, 8'd77, 1'b0);
    run_check(1'b1, 4, 8'd254, 1'b0);   // R8 wrap through zero
    run_check(1'b1, 150, 8'd3, 1'b1);   // R7 busy start
    run_check(1'b0, 10, 8'd255, 1'b1);
    // constrained random
    for (int i = 0; i < 12; i++) begin
      bit r;
      int p;
      logic [CW-1:0] pv;
      r  = ($urandom % 3) != 0;
      p  = 4 + ($urandom % 147);
      pv = CW'($urandom);
      run_check(r, p, pv, ($urandom % 4) == 0);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule